// File: doc/BRIEF.md
# Latched Fault Status Reporter

This block drives one active-high fault pin for an eight-channel output driver. The pin combines three kinds of input. Live fault inputs are the eight per-channel short-circuit flags, the live overtemperature flag and the standby indication; standby forces the pin high so the host can self-test the line. Latched faults are a frame that was too short, a frame that was too long, and a past overtemperature. Each latched fault is released at a different falling clock edge of a later serial frame. The host can therefore tell which fault happened by counting how far into the next command frame the pin drops.

Frame events come in as single-cycle pulses that are already synchronised to the system clock. They are the start of a frame (chip select falling), the end of a frame (chip select rising), and the rising and falling edges of the serial clock. A small state machine tracks the frame and counts its clock edges. Three set/clear flags hold the latched faults. The pin is a combinational OR of the live inputs and the flags, so a live fault shows in the same cycle. A latched fault shows from the cycle after the edge that sets or clears it.

The frame tracker has three states. FT_IDLE means no frame is open. FT_SHIFT means a frame is open and at most eight clocks have been seen. FT_EXCESS means a frame is open and a ninth clock has been seen. Transitions: FT_IDLE to FT_SHIFT on frame start. FT_SHIFT to FT_EXCESS on the ninth rising serial-clock edge. FT_SHIFT or FT_EXCESS to FT_IDLE on frame end. FT_SHIFT or FT_EXCESS to FT_SHIFT on a new frame start, which restarts the counts.

Top module: `fault_status_reporter`

## Requirements
- R1: `status_o` is high in the same cycle that any bit of `sc_flag_i` is high. Short-circuit flags are not latched: once they all drop, they no longer hold the pin high.
- R2: `status_o` is high in the same cycle that `ot_i` is high.
- R3: `status_o` is high while `stby_i` is high (standby self-test), and standby is not latched.
- R4: After reset, with all live inputs low and no frames, `status_o` is low.
- R5: A frame that ends in state FT_SHIFT with fewer than 8 serial-clock falling edges sets the under-count flag. `status_o` is high from the cycle after the frame-end pulse.
- R6: The under-count flag clears on the 8th falling edge of a later frame. It is still set after that frame's 7th falling edge.
- R7: The 9th rising serial-clock edge within one frame sets the over-count flag. `status_o` is high from the next cycle, including after the frame ends.
- R8: The over-count flag clears on the 2nd falling edge of a later frame. It is still set after that frame's 1st falling edge.
- R9: `ot_i` sets an overtemperature flag that outlasts the input. The flag clears on the 4th falling edge of a frame only if `ot_i` is low in that cycle. If `ot_i` is high in that cycle, setting wins and the flag stays.
- R10: A frame of exactly 8 clocks sets no flag.
- R11: A frame start while a frame is already open discards the old counts. The restarted frame alone decides whether a length error is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, clears all latched flags |
| sc_flag_i | input | 8 | Live short-circuit flag per channel |
| ot_i | input | 1 | Live overtemperature flag, hysteresis already applied |
| stby_i | input | 1 | High when all command bits are zero |
| frm_start_i | input | 1 | One-cycle pulse at chip-select falling edge |
| frm_end_i | input | 1 | One-cycle pulse at chip-select rising edge |
| sck_rise_i | input | 1 | One-cycle pulse at serial-clock rising edge |
| sck_fall_i | input | 1 | One-cycle pulse at serial-clock falling edge |
| status_o | output | 1 | Active-high combined fault status |

## Verification
The setting and the clearing of the overtemperature flag can land in the same cycle. This happens when the 4th falling serial edge of a frame arrives while `ot_i` is still high. The bench provokes it by holding `ot_i` high across that edge and dropping it two cycles later. It then judges the outcome at the pin: `status_o` must stay high after `ot_i` falls, and it must drop only at the 4th falling edge of the following frame. A behavioural model in the bench, built from edge counts, predicts the pin on every clock, and the named checks sample the pin just before and just after each clear point.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    typedef enum logic [1:0] {
        FT_IDLE   = 2'd0,
        FT_SHIFT  = 2'd1,
        FT_EXCESS = 2'd2
    } ft_state_e;

    localparam int LAT_UNDER = 0;
    localparam int LAT_OVER  = 1;
    localparam int LAT_OT    = 2;
    localparam int LAT_COUNT = 3;
endpackage

// File: rtl/fsr_flag_latch.sv
module fsr_flag_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_o)); // R6
    AST_LATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o); // R9
endmodule

// File: rtl/fsr_frame_tracker.sv
module fsr_frame_tracker
    import fsr_pkg::*;
#(
    parameter int FRAME_BITS     = 8,
    parameter int UNDER_CLR_FALL = 8,
    parameter int OVER_CLR_FALL  = 2,
    parameter int OT_CLR_FALL    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frm_start_i,
    input  logic frm_end_i,
    input  logic sck_rise_i,
    input  logic sck_fall_i,
    output logic under_set_o,
    output logic over_set_o,
    output logic under_clr_o,
    output logic over_clr_o,
    output logic ot_clr_pt_o
);
    localparam int            CW      = $clog2(FRAME_BITS + 2);
    localparam logic [CW-1:0] CNT_MAX = CW'(FRAME_BITS + 1);

    ft_state_e     state_q, state_d;
    logic [CW-1:0] fall_cnt_q, rise_cnt_q;
    logic          in_frame, ninth_rise;

    assign in_frame   = (state_q != FT_IDLE) && !frm_start_i;
    assign ninth_rise = (state_q == FT_SHIFT) && !frm_start_i && sck_rise_i
                        && (rise_cnt_q == CW'(FRAME_BITS));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= FT_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FT_IDLE: begin
                if (frm_start_i) state_d = FT_SHIFT;
            end
            FT_SHIFT: begin
                if (frm_start_i)    state_d = FT_SHIFT;
                else if (frm_end_i) state_d = FT_IDLE;
                else if (ninth_rise) state_d = FT_EXCESS;
            end
            FT_EXCESS: begin
                if (frm_start_i)    state_d = FT_SHIFT;
                else if (frm_end_i) state_d = FT_IDLE;
            end
            default: state_d = FT_IDLE;
        endcase
    end

    // edge counters, saturating one past a full frame
    always_ff @(posedge clk) begin
        if (!rst_n || frm_start_i) begin
            fall_cnt_q <= '0;
            rise_cnt_q <= '0;
        end else if (in_frame) begin
            if (sck_fall_i && fall_cnt_q != CNT_MAX) fall_cnt_q <= fall_cnt_q + 1'b1;
            if (sck_rise_i && rise_cnt_q != CNT_MAX) rise_cnt_q <= rise_cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        under_set_o = (state_q == FT_SHIFT) && !frm_start_i && frm_end_i
                      && (fall_cnt_q < CW'(FRAME_BITS));
        over_set_o  = ninth_rise;
        under_clr_o = in_frame && sck_fall_i && (fall_cnt_q == CW'(UNDER_CLR_FALL - 1));
        over_clr_o  = in_frame && sck_fall_i && (fall_cnt_q == CW'(OVER_CLR_FALL - 1));
        ot_clr_pt_o = in_frame && sck_fall_i && (fall_cnt_q == CW'(OT_CLR_FALL - 1));
    end

    AST_ONE_CLEAR_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({under_clr_o, over_clr_o, ot_clr_pt_o})); // R8
    AST_OVER_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        over_set_o |=> !over_set_o); // R7
    AST_NO_SET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FT_IDLE && !frm_start_i) |-> !(under_set_o || over_set_o)); // R11
endmodule

// File: rtl/fault_status_reporter.sv
module fault_status_reporter
    import fsr_pkg::*;
#(
    parameter int CHANNELS       = 8,
    parameter int FRAME_BITS     = 8,
    parameter int UNDER_CLR_FALL = 8,
    parameter int OVER_CLR_FALL  = 2,
    parameter int OT_CLR_FALL    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CHANNELS-1:0] sc_flag_i,
    input  logic                ot_i,
    input  logic                stby_i,
    input  logic                frm_start_i,
    input  logic                frm_end_i,
    input  logic                sck_rise_i,
    input  logic                sck_fall_i,
    output logic                status_o
);
    logic under_set, over_set, under_clr, over_clr, ot_clr_pt;
    logic [LAT_COUNT-1:0] lat_set, lat_clr, lat_q;

    fsr_frame_tracker #(
        .FRAME_BITS    (FRAME_BITS),
        .UNDER_CLR_FALL(UNDER_CLR_FALL),
        .OVER_CLR_FALL (OVER_CLR_FALL),
        .OT_CLR_FALL   (OT_CLR_FALL)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_start_i(frm_start_i),
        .frm_end_i  (frm_end_i),
        .sck_rise_i (sck_rise_i),
        .sck_fall_i (sck_fall_i),
        .under_set_o(under_set),
        .over_set_o (over_set),
        .under_clr_o(under_clr),
        .over_clr_o (over_clr),
        .ot_clr_pt_o(ot_clr_pt)
    );

    always_comb begin
        lat_set[LAT_UNDER] = under_set;
        lat_clr[LAT_UNDER] = under_clr;
        lat_set[LAT_OVER]  = over_set;
        lat_clr[LAT_OVER]  = over_clr;
        lat_set[LAT_OT]    = ot_i;
        lat_clr[LAT_OT]    = ot_clr_pt && !ot_i;
    end

    for (genvar g = 0; g < LAT_COUNT; g++) begin : g_lat
        fsr_flag_latch u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (lat_set[g]),
            .clr_i (lat_clr[g]),
            .flag_o(lat_q[g])
        );
    end

    assign status_o = (|sc_flag_i) | ot_i | stby_i | (|lat_q);

    AST_SC_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (|sc_flag_i) |-> status_o); // R1
    AST_OT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ot_i |-> status_o); // R2
    AST_STBY_SELFTEST: assert property (@(posedge clk) disable iff (!rst_n)
        stby_i |-> status_o); // R3
    AST_UNDER_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        under_set |=> status_o); // R5
    AST_OT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_i && ot_clr_pt) |=> lat_q[LAT_OT]); // R9
endmodule

// File: tb/fault_status_reporter_test.sv
`timescale 1ns/1ps
module fault_status_reporter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sc_flag = '0;
    logic       ot = 1'b0, stby = 1'b0;
    logic       fstart = 1'b0, fend = 1'b0, srise = 1'b0, sfall = 1'b0;
    logic       status;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    // behavioural model state
    bit m_inf = 0, m_exc = 0, m_under = 0, m_over = 0, m_ot = 0;
    int m_falls = 0, m_rises = 0;

    always #2.5 clk = ~clk;

    fault_status_reporter uut (
        .clk(clk), .rst_n(rst_n), .sc_flag_i(sc_flag), .ot_i(ot), .stby_i(stby),
        .frm_start_i(fstart), .frm_end_i(fend), .sck_rise_i(srise), .sck_fall_i(sfall),
        .status_o(status)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: status=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle model comparison
    always @(posedge clk) begin
        if (!rst_n) begin
            m_inf = 0; m_exc = 0; m_under = 0; m_over = 0; m_ot = 0;
            m_falls = 0; m_rises = 0;
        end else begin
            if (fstart) begin
                m_inf = 1; m_exc = 0; m_falls = 0; m_rises = 0;
            end else if (m_inf) begin
                if (sfall) begin
                    if (m_falls < 9) begin
                        m_falls++;
                        if (m_falls == 8) m_under = 0;
                        if (m_falls == 2) m_over = 0;
                        if (m_falls == 4 && !ot) m_ot = 0;
                    end
                end
                if (srise) begin
                    if (m_rises < 9) m_rises++;
                    if (m_rises == 9 && !m_exc) begin m_over = 1; m_exc = 1; end
                end
                if (fend) begin
                    if (!m_exc && m_falls < 8) m_under = 1;
                    m_inf = 0;
                end
            end
            if (ot) m_ot = 1;
        end
        #1;
        if (rst_n && !done)
            chk(status, (|sc_flag) | ot | stby | m_under | m_over | m_ot,
                "model R1 R2 R3 R5 R7 R9");
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: status=%0b expected=finish", status);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic pulse(ref logic s);
        @(negedge clk) s = 1'b1;
        @(negedge clk) s = 1'b0;
    endtask

    task automatic one_clock();
        pulse(srise);
        pulse(sfall);
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) one_clock();
    endtask

    task automatic probe(input logic exp, input string tag);
        #0.5 chk(status, exp, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        probe(1'b0, "R4 reset idle");

        // R1: each short-circuit channel, live only
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) sc_flag = 8'(1 << i);
            probe(1'b1, "R1 sc live");
            @(negedge clk) sc_flag = '0;
            probe(1'b0, "R1 sc not latched");
        end

        // R3: standby self-test
        @(negedge clk) stby = 1'b1;
        probe(1'b1, "R3 standby high");
        @(negedge clk) stby = 1'b0;
        probe(1'b0, "R3 standby released");

        // R2/R9: overtemperature latched, cleared at 4th fall
        @(negedge clk) ot = 1'b1;
        probe(1'b1, "R2 ot live");
        @(negedge clk) ot = 1'b0;
        @(negedge clk);
        probe(1'b1, "R9 ot latched");
        pulse(fstart);
        clocks(3);
        probe(1'b1, "R9 ot kept after 3rd fall");
        one_clock();
        probe(1'b0, "R9 ot cleared at 4th fall");
        clocks(4);
        pulse(fend);
        @(negedge clk);
        probe(1'b0, "R10 exact eight clocks no flag");

        // R9: ot still high at the clear point, set wins
        @(negedge clk) ot = 1'b1;
        pulse(fstart);
        clocks(4);
        @(negedge clk);
        @(negedge clk) ot = 1'b0;
        probe(1'b1, "R9 set wins at clear point");
        clocks(4);
        pulse(fend);
        pulse(fstart);
        clocks(3);
        probe(1'b1, "R9 held into next frame");
        one_clock();
        probe(1'b0, "R9 cleared next frame");
        clocks(4);
        pulse(fend);

        // R5/R6: under-count
        pulse(fstart);
        clocks(5);
        pulse(fend);
        probe(1'b1, "R5 under-count latched");
        pulse(fstart);
        clocks(7);
        probe(1'b1, "R6 kept after 7th fall");
        one_clock();
        probe(1'b0, "R6 cleared at 8th fall");
        pulse(fend);
        @(negedge clk);
        probe(1'b0, "R6 stays clear");

        // R7/R8: over-count
        pulse(fstart);
        clocks(8);
        probe(1'b0, "R7 not set by 8 clocks");
        pulse(srise);
        probe(1'b1, "R7 set at 9th rise");
        pulse(sfall);
        pulse(fend);
        probe(1'b1, "R7 held after frame");
        pulse(fstart);
        one_clock();
        probe(1'b1, "R8 kept after 1st fall");
        one_clock();
        probe(1'b0, "R8 cleared at 2nd fall");
        clocks(6);
        pulse(fend);
        @(negedge clk);
        probe(1'b0, "R8 full frame leaves clear");

        // R11: restart mid-frame
        pulse(fstart);
        clocks(3);
        pulse(fstart);
        clocks(8);
        pulse(fend);
        @(negedge clk);
        probe(1'b0, "R11 restart then full frame");
        pulse(fstart);
        clocks(8);
        pulse(fstart);
        clocks(2);
        pulse(fend);
        probe(1'b1, "R11 restart then short frame");
        pulse(fstart);
        clocks(8);
        pulse(fend);
        probe(1'b0, "R6 cleared after restart case");

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule